// File: doc/BRIEF.md
# Three-Dimensional Strided Address Generator

This block turns one programmed access-pattern descriptor into a stream of memory word addresses. The descriptor describes three nested affine loops. The innermost loop walks a contiguous run of consecutive words. The middle loop repeats that run, with each run starting a fixed stride after the start of the run before it, and so forms a two-dimensional plane. The outer loop repeats whole planes, with each plane starting a fixed span after the start of the plane before it. Each emitted address is the base offset plus the sum of every loop index times that loop's step.

Software or a sequencer writes the six descriptor fields through a load strobe while the block is idle, then pulses start. Addresses leave on a valid/ready handshake, so a downstream memory port can apply backpressure at any time. A one-cycle done pulse marks the end of the pattern. A degenerate descriptor, meaning one with any repeat count of zero, ends at once without emitting anything.

Top module: `stride3d_agen`

## Requirements
- R1: After reset, `valid_o`, `done_o` and `busy_o` are low.
- R2: `load_i` captures all six descriptor fields on a clock edge while the block is idle. A load while a pattern is in progress is ignored, and the pattern in progress continues with its original fields.
- R3: The first address after a start equals the loaded offset.
- R4: Inside a run, consecutive addresses differ by +1, and each run holds exactly `run_len_i` addresses.
- R5: Each run starts `stride_i` words after the start of the previous run in the same plane, and a plane holds exactly `run_cnt_i` runs.
- R6: Each plane starts `span_i` words after the start of the previous plane, and the pattern holds exactly `plane_cnt_i` planes. The total address count is run_len × run_cnt × plane_cnt.
- R7: The address advances only on a clock edge where `valid_o` and `ready_i` are both high. While `valid_o` is high and `ready_i` is low, `valid_o` stays high and `addr_o` holds its value.
- R8: A start with any of `run_len`, `run_cnt` or `plane_cnt` equal to zero emits no address. In that case `done_o` is high for the one cycle after the start edge.
- R9: `done_o` is a one-cycle pulse in the cycle after the last handshake, and `valid_o` is low in that cycle.
- R10: All address arithmetic wraps modulo 2^ADDR_W.
- R11: A start pulse while a pattern is in progress is ignored, and the address sequence in progress is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Descriptor capture strobe |
| offset_i | input | ADDR_W | Address of the first word |
| run_len_i | input | CNT_W | Words per contiguous run |
| stride_i | input | ADDR_W | Distance between run starts |
| run_cnt_i | input | CNT_W | Runs per plane |
| span_i | input | ADDR_W | Distance between plane starts |
| plane_cnt_i | input | CNT_W | Planes per pattern |
| start_i | input | 1 | Starts a pattern when idle |
| ready_i | input | 1 | Downstream accepts the address |
| valid_o | output | 1 | Address is valid |
| addr_o | output | ADDR_W | Current word address |
| busy_o | output | 1 | Pattern in progress |
| done_o | output | 1 | One-cycle end-of-pattern pulse |

## Verification
The in-RTL assertions check the following on every cycle: the output holds under backpressure, each in-run step is +1, every loop index stays below its limit, the done pulse lasts one cycle with valid low, a fresh pattern opens at the offset, and a start while busy keeps the pattern alive. Some behaviours cannot be expressed as single-cycle properties. These are the exact run and plane jumps across several loop shapes, the total address count, the immediate finish on a zero count, modulo wrap-around, and the way a mid-run load or start is ignored. Only the bench scenarios show them, by comparing every accepted address with a nested-loop model under varied ready patterns.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int unsigned NUM_LVL = 3;
  localparam int unsigned LVL_RUN   = 0;
  localparam int unsigned LVL_ROW   = 1;
  localparam int unsigned LVL_PLANE = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } agen_state_e;
endpackage

// File: rtl/agen_desc_reg.sv
module agen_desc_reg #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [CNT_W-1:0]  run_len_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [CNT_W-1:0]  run_cnt_i,
  input  logic [ADDR_W-1:0] span_i,
  input  logic [CNT_W-1:0]  plane_cnt_i,
  output logic [ADDR_W-1:0] offset_o,
  output logic [ADDR_W-1:0] stride_o,
  output logic [ADDR_W-1:0] span_o,
  output logic [CNT_W-1:0]  run_len_o,
  output logic [CNT_W-1:0]  run_cnt_o,
  output logic [CNT_W-1:0]  plane_cnt_o,
  output logic              empty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_o    <= '0;
      stride_o    <= '0;
      span_o      <= '0;
      run_len_o   <= '0;
      run_cnt_o   <= '0;
      plane_cnt_o <= '0;
    end else if (cap_i) begin
      offset_o    <= offset_i;
      stride_o    <= stride_i;
      span_o      <= span_i;
      run_len_o   <= run_len_i;
      run_cnt_o   <= run_cnt_i;
      plane_cnt_o <= plane_cnt_i;
    end
  end

  assign empty_o = (run_len_o == '0) || (run_cnt_o == '0) || (plane_cnt_o == '0);
endmodule

// File: rtl/agen_idx_ctr.sv
module agen_idx_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_o <= '0;
    else if (clr_i) idx_o <= '0;
    else if (inc_i) idx_o <= idx_o + 1'b1;
  end

  assign last_o = (idx_o == limit_i - 1'b1);

  // index never passes its limit while stepping
  assert_idx_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> (idx_o < limit_i));
endmodule

// File: rtl/agen_addr_gen.sv
module agen_addr_gen #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              step_i,
  input  logic              run_end_i,
  input  logic              plane_end_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [ADDR_W-1:0] span_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] row_base_q, plane_base_q;
  logic [ADDR_W-1:0] next_row, next_plane;

  assign next_row   = row_base_q + stride_i;
  assign next_plane = plane_base_q + span_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o       <= '0;
      row_base_q   <= '0;
      plane_base_q <= '0;
    end else if (init_i) begin
      addr_o       <= offset_i;
      row_base_q   <= offset_i;
      plane_base_q <= offset_i;
    end else if (step_i) begin
      if (!run_end_i) begin
        addr_o <= addr_o + 1'b1;
      end else if (!plane_end_i) begin
        addr_o     <= next_row;
        row_base_q <= next_row;
      end else begin
        addr_o       <= next_plane;
        row_base_q   <= next_plane;
        plane_base_q <= next_plane;
      end
    end
  end
endmodule

// File: rtl/stride3d_agen.sv
module stride3d_agen
  import agen_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [CNT_W-1:0]  run_len_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [CNT_W-1:0]  run_cnt_i,
  input  logic [ADDR_W-1:0] span_i,
  input  logic [CNT_W-1:0]  plane_cnt_i,
  input  logic              start_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              done_o
);
  agen_state_e state_q;
  logic [ADDR_W-1:0] d_offset, d_stride, d_span;
  logic [CNT_W-1:0]  d_run_len, d_run_cnt, d_plane_cnt;
  logic              d_empty, idle, go, skip, step, finish;
  logic [CNT_W-1:0]  lim [NUM_LVL];
  logic [CNT_W-1:0]  idx [NUM_LVL];
  logic              last [NUM_LVL];
  logic              wrap [NUM_LVL];

  assign idle = (state_q == ST_IDLE);

  agen_desc_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_desc (
    .clk_i, .rst_ni,
    .cap_i      (load_i && idle),
    .offset_i, .run_len_i, .stride_i, .run_cnt_i, .span_i, .plane_cnt_i,
    .offset_o   (d_offset),
    .stride_o   (d_stride),
    .span_o     (d_span),
    .run_len_o  (d_run_len),
    .run_cnt_o  (d_run_cnt),
    .plane_cnt_o(d_plane_cnt),
    .empty_o    (d_empty)
  );

  assign go     = start_i && idle && !d_empty;
  assign skip   = start_i && idle && d_empty;
  assign step   = valid_o && ready_i;
  assign finish = step && last[LVL_RUN] && last[LVL_ROW] && last[LVL_PLANE];

  assign lim[LVL_RUN]   = d_run_len;
  assign lim[LVL_ROW]   = d_run_cnt;
  assign lim[LVL_PLANE] = d_plane_cnt;

  // wrap[k]: level k and every inner level are at their last index
  assign wrap[0] = last[0];
  for (genvar k = 1; k < NUM_LVL; k++) begin : g_wrap
    assign wrap[k] = wrap[k-1] && last[k];
  end

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
    logic inc_k;
    if (k == 0) begin : g_inner
      assign inc_k = step;
    end else begin : g_outer
      assign inc_k = step && wrap[k-1];
    end
    agen_idx_ctr #(.CNT_W(CNT_W)) i_ctr (
      .clk_i, .rst_ni,
      .clr_i  (go || (step && wrap[k])),
      .inc_i  (inc_k),
      .limit_i(lim[k]),
      .idx_o  (idx[k]),
      .last_o (last[k])
    );
  end

  agen_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
    .clk_i, .rst_ni,
    .init_i     (go),
    .step_i     (step),
    .run_end_i  (last[LVL_RUN]),
    .plane_end_i(wrap[LVL_ROW]),
    .offset_i   (d_offset),
    .stride_i   (d_stride),
    .span_i     (d_span),
    .addr_o     (addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
    end else begin
      done_o <= skip || finish;
      if (go)          state_q <= ST_RUN;
      else if (finish) state_q <= ST_IDLE;
    end
  end

  assign valid_o = (state_q == ST_RUN);
  assign busy_o  = valid_o;

  assert_stall_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o)));

  assert_run_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !last[LVL_RUN]) |=> (addr_o == $past(addr_o) + 1'b1));

  assert_first_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (addr_o == d_offset));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!valid_o ##1 !done_o));

  assert_start_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && start_i && !finish) |=> valid_o);
endmodule

// File: tb/test_stride3d_agen.sv
module test_stride3d_agen;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned CNT_W  = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic load_i = 1'b0, start_i = 1'b0, ready_i = 1'b0;
  logic [ADDR_W-1:0] offset_i = '0, stride_i = '0, span_i = '0;
  logic [CNT_W-1:0]  run_len_i = '0, run_cnt_i = '0, plane_cnt_i = '0;
  logic valid_o, busy_o, done_o;
  logic [ADDR_W-1:0] addr_o;

  int checks = 0;
  int fails  = 0;
  logic [ADDR_W-1:0] ref_q[$];

  always #10ns clk = ~clk;

  stride3d_agen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_stride3d_agen (
    .clk_i(clk), .rst_ni, .load_i, .offset_i, .run_len_i, .stride_i,
    .run_cnt_i, .span_i, .plane_cnt_i, .start_i, .ready_i,
    .valid_o, .addr_o, .busy_o, .done_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_desc(input logic [ADDR_W-1:0] off, input int h,
                           input logic [ADDR_W-1:0] str, input int v,
                           input logic [ADDR_W-1:0] sp, input int d);
    @(negedge clk);
    offset_i = off; run_len_i = CNT_W'(h); stride_i = str;
    run_cnt_i = CNT_W'(v); span_i = sp; plane_cnt_i = CNT_W'(d);
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    ref_q.delete();
    for (int p = 0; p < d; p++)
      for (int r = 0; r < v; r++)
        for (int w = 0; w < h; w++)
          ref_q.push_back(off + ADDR_W'(p) * sp + ADDR_W'(r) * str + ADDR_W'(w));
  endtask

  // mode 0: always ready, 1: ready 2 of 3 cycles, 2: ready 1 of 4 cycles
  task automatic run_pat(input int mode, input bit disturb, input string req);
    int cyc = 0;
    int total = ref_q.size();
    int seen = 0;
    bit first = 1'b1;
    bit stalled = 1'b0;
    bit expect_done = 1'b0;
    logic [ADDR_W-1:0] held = '0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    forever begin
      case (mode)
        0: ready_i = 1'b1;
        1: ready_i = (cyc % 3) != 2;
        default: ready_i = (cyc % 4) == 3;
      endcase
      if (disturb && cyc == 3) begin
        load_i = 1'b1; start_i = 1'b1;
        offset_i = 32'hDEAD_0000; run_len_i = 1; run_cnt_i = 1; plane_cnt_i = 1;
      end else if (disturb && cyc == 4) begin
        load_i = 1'b0; start_i = 1'b0;
      end
      #1;
      if (stalled) chk(valid_o && addr_o == held, "R7 hold under stall", addr_o, held);
      if (expect_done) begin
        chk(done_o === 1'b1 && valid_o === 1'b0, "R9 done after last", {done_o, valid_o}, 2'b10);
        break;
      end
      chk(valid_o === 1'b1 && !done_o, "R9 valid during pattern", {done_o, valid_o}, 2'b01);
      if (first) begin
        chk(addr_o == ref_q[0], "R3 first address", addr_o, ref_q[0]);
        first = 1'b0;
      end
      stalled = valid_o && !ready_i;
      held = addr_o;
      if (valid_o && ready_i) begin
        chk(ref_q.size() > 0 && addr_o == ref_q[0], req, addr_o, ref_q.size() > 0 ? ref_q[0] : 0);
        if (ref_q.size() > 0) void'(ref_q.pop_front());
        seen++;
        if (ref_q.size() == 0) expect_done = 1'b1;
      end
      cyc++;
      if (cyc > 20000) begin
        chk(1'b0, "watchdog pattern", cyc, 0);
        break;
      end
      @(negedge clk);
    end
    chk(seen == total, "R6 address count", seen, total);
    @(negedge clk); #1;
    chk(done_o === 1'b0 && busy_o === 1'b0, "R9 done single pulse", {done_o, busy_o}, 0);
    ready_i = 1'b0;
  endtask

  initial begin
    #1;
    chk(valid_o === 1'b0 && done_o === 1'b0 && busy_o === 1'b0, "R1 reset state",
        {valid_o, done_o, busy_o}, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(valid_o === 1'b0 && done_o === 1'b0 && busy_o === 1'b0, "R1 after release",
        {valid_o, done_o, busy_o}, 0);

    load_desc(32'h100, 4, 32'h10, 3, 32'h100, 2);
    run_pat(0, 1'b0, "R4 R5 R6 full speed");
    load_desc(32'h2000, 3, 32'h8, 4, 32'h40, 3);
    run_pat(1, 1'b0, "R7 backpressure 2of3");
    load_desc(32'h500, 1, 32'h20, 5, 32'h7, 2);
    run_pat(2, 1'b0, "R5 single-word runs");
    load_desc(32'h40, 5, 32'h0, 1, 32'h3, 4);
    run_pat(1, 1'b0, "R6 planes of one run");
    load_desc(32'hFFFF_FFFC, 3, 32'h2, 2, 32'h8, 2);
    run_pat(0, 1'b0, "R10 wrap modulo");
    load_desc(32'h3000, 4, 32'h10, 2, 32'h80, 2);
    run_pat(0, 1'b1, "R2 R11 load and start while busy ignored");

    // R8: zero count in each position
    for (int z = 0; z < 3; z++) begin
      load_desc(32'h700, z == 0 ? 0 : 2, 32'h4, z == 1 ? 0 : 2, 32'h10, z == 2 ? 0 : 2);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      #1;
      chk(done_o === 1'b1 && valid_o === 1'b0, "R8 zero count done", {done_o, valid_o}, 2'b10);
      @(negedge clk); #1;
      chk(done_o === 1'b0 && valid_o === 1'b0, "R8 zero count no output", {done_o, valid_o}, 0);
    end

    // R2: descriptor loaded while idle is used by the next start
    load_desc(32'h9000, 2, 32'h5, 2, 32'h30, 1);
    run_pat(2, 1'b0, "R2 reload while idle");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20ns);
    fails++;
    $display("FAIL watchdog global actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule